// File: doc/BRIEF.md
# Width-Selectable Integer Adder with Status Flags

This block adds two integer operands at one of four operand widths and returns the sum together with six arithmetic status flags: carry, signed overflow, sign, zero, nibble (auxiliary) carry and parity. The second operand is either a register-style full-width source or an immediate. A short immediate is always 8 bits wide. A long immediate is as wide as the operand, but never wider than `IMM_W` bits. Either kind is sign-extended to the operand width before the addition.

An execution pipeline presents one operation per strobe. The result, the flags and a valid strobe appear on the next clock. A request for an atomic (locked) operation is legal only when the destination is a memory operand. When a locked request targets a register, the block does not produce a result. Instead it pulses an undefined-opcode fault, and the previous result and flags stay on the outputs unchanged.

Top module: `wadd_unit`

## Requirements
- R1: `res` equals (destination + source) modulo 2^W, where W is the selected width. Result bits at W and above are zero, and operand bits at W and above have no effect.
- R2: With `imm_sel`=1 the source is the immediate, not `src_opnd`. If `imm_short`=1, `imm_opnd[7:0]` is sign-extended to W. Otherwise `imm_opnd[min(W,IMM_W)-1:0]` is sign-extended to W.
- R3: `flag_cf` is the unsigned carry out of bit W-1.
- R4: `flag_of` is 1 exactly when both addends have the same sign bit (bit W-1) and the result's sign bit differs from it.
- R5: `flag_sf` equals result bit W-1.
- R6: `flag_zf` is 1 exactly when the W result bits are all zero.
- R7: `flag_af` is the carry from bit 3 into bit 4 of the addition, at every width.
- R8: `flag_pf` is 1 when `res[7:0]` holds an even number of ones, at every width.
- R9: `size_sel` encodes W as 00=8, 01=16, 10=32, 11=64 (with `DATA_W`=64; in general `DATA_W`>>(3-size_sel)).
- R10: `out_vld` is high for exactly the one cycle after a committed `in_vld`, and at no other time.
- R11: `in_vld` with `lock_req`=1 and `dst_is_mem`=0 makes `ud_fault` high in the next cycle with `out_vld` low. `res` and all flags keep their previous values.
- R12: `lock_req`=1 with `dst_is_mem`=1 is a legal request and completes like an unlocked one.
- R13: After synchronous reset, `out_vld`, `ud_fault`, `res` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operation strobe |
| size_sel | input | 2 | Operand width code |
| dst_opnd | input | DATA_W | Destination (first) addend |
| src_opnd | input | DATA_W | Register/memory source addend |
| imm_opnd | input | IMM_W | Immediate source value |
| imm_sel | input | 1 | Use the immediate as the source |
| imm_short | input | 1 | Immediate is 8 bits wide |
| lock_req | input | 1 | Atomic operation requested |
| dst_is_mem | input | 1 | Destination is a memory operand |
| out_vld | output | 1 | Result and flags valid |
| res | output | DATA_W | Sum at the selected width, zero above it |
| flag_cf | output | 1 | Unsigned carry |
| flag_of | output | 1 | Signed overflow |
| flag_sf | output | 1 | Sign |
| flag_zf | output | 1 | Zero |
| flag_af | output | 1 | Carry out of bit 3 |
| flag_pf | output | 1 | Even parity of low byte |
| ud_fault | output | 1 | Illegal lock request fault |

## Verification
The bench uses the default `DATA_W`=64 and `IMM_W`=32. With these values all four width codes are available, and the 64-bit case extends a 32-bit immediate, so it is the one width where the long immediate is narrower than the operand. Directed vectors drive the flag boundaries at each width: signed wrap, unsigned wrap to zero, and a nibble carry. They also load junk into the operand bits above the selected width. Further vectors cover the lock legality cases, including a fault issued back to back with committed operations. A longer stretch of varied operands, widths and immediate forms then follows.

// File: rtl/wadd_pkg.sv
// wadd_pkg: shared width codes and flag bundle for the sized adder.
// Assumes the operand width is DATA_W >> (3 - code).
package wadd_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'b00,
        SZ_H = 2'b01,
        SZ_W = 2'b10,
        SZ_F = 2'b11
    } opsz_e;

    localparam int NUM_SZ = 4;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
    } aflags_t;

endpackage

// File: rtl/wadd_immext.sv
// wadd_immext: sign-extends the immediate to the selected operand width.
// Short form extends bits [7:0]; long form extends min(width, IMM_W) bits.
// Assumes IMM_W >= 8 and IMM_W <= DATA_W. The output is full DATA_W wide;
// the adder core masks it down to the selected width.
module wadd_immext
    import wadd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              imm_short,
    input  logic [1:0]        size_sel,
    output logic [DATA_W-1:0] imm_ext
);
    localparam int SHORT_W = 8;

    logic [DATA_W-1:0] long_by_sz [NUM_SZ];
    logic [DATA_W-1:0] short_ext;

    // One long-form extension per width code.
    for (genvar i = 0; i < NUM_SZ; i++) begin : g_long
        localparam int LW = DATA_W >> (NUM_SZ - 1 - i);
        localparam int IW = (LW < IMM_W) ? LW : IMM_W;
        if (IW < DATA_W) begin : g_ext
            assign long_by_sz[i] = {{(DATA_W-IW){imm[IW-1]}}, imm[IW-1:0]};
        end else begin : g_full
            assign long_by_sz[i] = imm[DATA_W-1:0];
        end
    end

    assign short_ext = {{(DATA_W-SHORT_W){imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};

    // Pick the short or width-appropriate long form.
    always_comb begin
        imm_ext = imm_short ? short_ext : long_by_sz[size_sel];
    end

endmodule

// File: rtl/wadd_core.sv
// wadd_core: one shared adder over width-masked operands plus flag logic.
// Operand bits above the selected width are cleared before the add, so the
// carry out of the selected width lands in bit W of the full-width sum.
module wadd_core
    import wadd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [1:0]        size_sel,
    output logic [DATA_W-1:0] sum,
    output aflags_t           flg
);
    localparam int NIB = 4;
    localparam int BYTE_W = 8;

    logic [DATA_W-1:0] mask_by_sz [NUM_SZ];
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] am, bm;
    logic [DATA_W:0]   wide;
    logic [NUM_SZ-1:0] cy_by_sz, sa_by_sz, sb_by_sz, sr_by_sz;

    // Width masks and per-width bit taps for carry and sign positions.
    for (genvar i = 0; i < NUM_SZ; i++) begin : g_sz
        localparam int LW = DATA_W >> (NUM_SZ - 1 - i);
        if (LW < DATA_W) begin : g_part
            assign mask_by_sz[i] = {{(DATA_W-LW){1'b0}}, {LW{1'b1}}};
        end else begin : g_all
            assign mask_by_sz[i] = '1;
        end
        assign cy_by_sz[i] = wide[LW];
        assign sa_by_sz[i] = am[LW-1];
        assign sb_by_sz[i] = bm[LW-1];
        assign sr_by_sz[i] = wide[LW-1];
    end

    // Mask operands, add once, and trim the sum to the lane.
    always_comb begin
        lane_mask = mask_by_sz[size_sel];
        am        = a_in & lane_mask;
        bm        = b_in & lane_mask;
        wide      = {1'b0, am} + {1'b0, bm};
        sum       = wide[DATA_W-1:0] & lane_mask;
    end

    // Derive the six status flags from the taps and the trimmed sum.
    always_comb begin
        flg.cf = cy_by_sz[size_sel];
        flg.sf = sr_by_sz[size_sel];
        flg.of = (sa_by_sz[size_sel] == sb_by_sz[size_sel]) &&
                 (sr_by_sz[size_sel] != sa_by_sz[size_sel]);
        flg.zf = (sum == '0);
        flg.af = am[NIB] ^ bm[NIB] ^ wide[NIB];
        flg.pf = ~^sum[BYTE_W-1:0];
    end

endmodule

// File: rtl/wadd_lockchk.sv
// wadd_lockchk: classifies a strobed request as committed or faulting.
// A locked request is legal only when the destination is memory.
module wadd_lockchk (
    input  logic in_vld,
    input  logic lock_req,
    input  logic dst_is_mem,
    output logic commit,
    output logic fault
);
    logic illegal;

    // Split the strobe into a commit path and a fault path.
    always_comb begin
        illegal = lock_req && !dst_is_mem;
        commit  = in_vld && !illegal;
        fault   = in_vld && illegal;
    end

endmodule

// File: rtl/wadd_unit.sv
// wadd_unit: width-selectable adder with status flags and a lock check.
// One clock from in_vld to out_vld or ud_fault. A fault leaves res and the
// flags untouched. Assumes DATA_W is a multiple of 8 and at least 64 bits
// wide enough that DATA_W>>3 >= 8.
module wadd_unit
    import wadd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [1:0]        size_sel,
    input  logic [DATA_W-1:0] dst_opnd,
    input  logic [DATA_W-1:0] src_opnd,
    input  logic [IMM_W-1:0]  imm_opnd,
    input  logic              imm_sel,
    input  logic              imm_short,
    input  logic              lock_req,
    input  logic              dst_is_mem,
    output logic              out_vld,
    output logic [DATA_W-1:0] res,
    output logic              flag_cf,
    output logic              flag_of,
    output logic              flag_sf,
    output logic              flag_zf,
    output logic              flag_af,
    output logic              flag_pf,
    output logic              ud_fault
);
    localparam int W8  = DATA_W >> 3;
    localparam int W16 = DATA_W >> 2;
    localparam int W32 = DATA_W >> 1;

    logic [DATA_W-1:0] imm_ext, src_use, sum_d;
    aflags_t           flg_d, flg_q;
    logic              commit, fault;
    logic [1:0]        size_q;

    wadd_immext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_immext (
        .imm       (imm_opnd),
        .imm_short (imm_short),
        .size_sel  (size_sel),
        .imm_ext   (imm_ext)
    );

    // Choose the immediate or the full-width source.
    always_comb begin
        src_use = imm_sel ? imm_ext : src_opnd;
    end

    wadd_core #(.DATA_W(DATA_W)) u_core (
        .a_in     (dst_opnd),
        .b_in     (src_use),
        .size_sel (size_sel),
        .sum      (sum_d),
        .flg      (flg_d)
    );

    wadd_lockchk u_lockchk (
        .in_vld     (in_vld),
        .lock_req   (lock_req),
        .dst_is_mem (dst_is_mem),
        .commit     (commit),
        .fault      (fault)
    );

    // Output stage: commit result and flags, or flag a fault and hold them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            ud_fault <= 1'b0;
            res      <= '0;
            flg_q    <= '0;
            size_q   <= 2'b00;
        end else begin
            out_vld  <= commit;
            ud_fault <= fault;
            if (commit) begin
                res    <= sum_d;
                flg_q  <= flg_d;
                size_q <= size_sel;
            end
        end
    end

    assign flag_cf = flg_q.cf;
    assign flag_of = flg_q.of;
    assign flag_sf = flg_q.sf;
    assign flag_zf = flg_q.zf;
    assign flag_af = flg_q.af;
    assign flag_pf = flg_q.pf;

    // Checker-side view of the committed lane: its top bit and upper mask.
    logic              res_msb;
    logic [DATA_W-1:0] upper_mask;
    always_comb begin
        case (size_q)
            SZ_B:    begin res_msb = res[W8-1];     upper_mask = ~{{(DATA_W-W8){1'b0}},  {W8{1'b1}}};  end
            SZ_H:    begin res_msb = res[W16-1];    upper_mask = ~{{(DATA_W-W16){1'b0}}, {W16{1'b1}}}; end
            SZ_W:    begin res_msb = res[W32-1];    upper_mask = ~{{(DATA_W-W32){1'b0}}, {W32{1'b1}}}; end
            default: begin res_msb = res[DATA_W-1]; upper_mask = '0;                                   end
        endcase
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !(lock_req && !dst_is_mem)) |=> out_vld); // R10
    AST_NO_SPONTANEOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld) |=> !out_vld && !ud_fault); // R10
    AST_FAULT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && lock_req && !dst_is_mem) |=> ud_fault && !out_vld); // R11
    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> $stable(res) && $stable(flg_q)); // R11
    AST_LEGAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && lock_req && dst_is_mem) |=> out_vld && !ud_fault); // R12
    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((res & upper_mask) == '0)); // R1
    AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (flag_sf == res_msb)); // R5
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (flag_zf == (res == '0))); // R6
    AST_PARITY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (flag_pf == ~^res[7:0])); // R8

endmodule

// File: tb/wadd_unit_bench.sv
// Scoreboard bench: the driver computes expectations from the requirements
// and queues them; the monitor compares at the cycle each one falls due.
module wadd_unit_bench;
    localparam int DATA_W = 64;
    localparam int IMM_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic [1:0]        size_sel = 2'b00;
    logic [DATA_W-1:0] dst_opnd = '0, src_opnd = '0;
    logic [IMM_W-1:0]  imm_opnd = '0;
    logic              imm_sel = 1'b0, imm_short = 1'b0;
    logic              lock_req = 1'b0, dst_is_mem = 1'b0;
    logic              out_vld, ud_fault;
    logic [DATA_W-1:0] res;
    logic              flag_cf, flag_of, flag_sf, flag_zf, flag_af, flag_pf;

    wadd_unit #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_wadd_unit (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .size_sel(size_sel),
        .dst_opnd(dst_opnd), .src_opnd(src_opnd), .imm_opnd(imm_opnd),
        .imm_sel(imm_sel), .imm_short(imm_short), .lock_req(lock_req),
        .dst_is_mem(dst_is_mem), .out_vld(out_vld), .res(res),
        .flag_cf(flag_cf), .flag_of(flag_of), .flag_sf(flag_sf),
        .flag_zf(flag_zf), .flag_af(flag_af), .flag_pf(flag_pf),
        .ud_fault(ud_fault)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          due;
        logic        vld;
        logic        flt;
        logic [63:0] r;
        logic [5:0]  f; // {cf, of, sf, zf, af, pf}
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    logic [63:0] last_r = '0;
    logic [5:0]  last_f = '0;
    bit          mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic fail(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_bad++;
        $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    endtask

    // Reference model built from R1-style definitions, independent of the RTL.
    task automatic model(input logic [1:0] sz, input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] im, input bit isel, input bit ishort,
                         output logic [63:0] r, output logic [5:0] f);
        int          w;
        logic [63:0] m, a, b, bx;
        logic [64:0] t;
        logic        sa, sb_, sr;
        w = 8 << sz;                                  // R9 width code
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        if (!isel)        bx = s;
        else if (ishort)  bx = 64'($signed(im[7:0]));  // R2 short form
        else if (w == 8)  bx = 64'($signed(im[7:0]));
        else if (w == 16) bx = 64'($signed(im[15:0]));
        else              bx = 64'($signed(im[31:0])); // R2 long form, capped
        a = d & m;
        b = bx & m;
        t = {1'b0, a} + {1'b0, b};
        r = t[63:0] & m;
        sa = a[w-1]; sb_ = b[w-1]; sr = r[w-1];
        f[5] = t[w];
        f[4] = (sa == sb_) && (sr != sa);
        f[3] = sr;
        f[2] = (r == 64'd0);
        f[1] = ((a & 64'hF) + (b & 64'hF)) > 64'hF;
        f[0] = ~^r[7:0];
    endtask

    task automatic apply(input logic [1:0] sz, input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] im, input bit isel, input bit ishort,
                         input bit lck, input bit mem);
        exp_t        e;
        logic [63:0] r;
        logic [5:0]  f;
        @(negedge clk);
        in_vld = 1'b1; size_sel = sz; dst_opnd = d; src_opnd = s; imm_opnd = im;
        imm_sel = isel; imm_short = ishort; lock_req = lck; dst_is_mem = mem;
        model(sz, d, s, im, isel, ishort, r, f);
        e.due = cyc + 1;
        if (lck && !mem) begin
            e.vld = 1'b0; e.flt = 1'b1; e.r = last_r; e.f = last_f;
        end else begin
            e.vld = 1'b1; e.flt = 1'b0; e.r = r; e.f = f;
            last_r = r; last_f = f;
        end
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0; lock_req = 1'b0;
        end
    endtask

    // Monitor: compare the due item, and flag any output nobody asked for.
    always @(negedge clk) begin
        if (mon_on) begin
            if (sb.size() != 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (out_vld !== e.vld)  fail("R10 out_vld", 64'(out_vld), 64'(e.vld));
                if (ud_fault !== e.flt) fail("R11 ud_fault", 64'(ud_fault), 64'(e.flt));
                if (res !== e.r)        fail("R1/R2 res", res, e.r);
                if (flag_cf !== e.f[5]) fail("R3 cf", 64'(flag_cf), 64'(e.f[5]));
                if (flag_of !== e.f[4]) fail("R4 of", 64'(flag_of), 64'(e.f[4]));
                if (flag_sf !== e.f[3]) fail("R5 sf", 64'(flag_sf), 64'(e.f[3]));
                if (flag_zf !== e.f[2]) fail("R6 zf", 64'(flag_zf), 64'(e.f[2]));
                if (flag_af !== e.f[1]) fail("R7 af", 64'(flag_af), 64'(e.f[1]));
                if (flag_pf !== e.f[0]) fail("R8 pf", 64'(flag_pf), 64'(e.f[0]));
            end else if (out_vld || ud_fault) begin
                fail("R10 unexpected strobe", {62'd0, out_vld, ud_fault}, 64'd0);
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fail("watchdog", 64'(cyc), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R13: reset state at the ports.
        n_vec++;
        if (out_vld !== 1'b0 || ud_fault !== 1'b0)
            fail("R13 strobes", {62'd0, out_vld, ud_fault}, 64'd0);
        if (res !== 64'd0) fail("R13 res", res, 64'd0);
        if ({flag_cf, flag_of, flag_sf, flag_zf, flag_af, flag_pf} !== 6'd0)
            fail("R13 flags", 64'({flag_cf, flag_of, flag_sf, flag_zf, flag_af, flag_pf}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R4/R7/R5: 8-bit signed wrap with nibble carry; junk above bit 7 (R1).
        apply(2'b00, 64'hDEAD_BEEF_CAFE_F07F, 64'h1234_5678_9ABC_DE01, 32'd0, 0, 0, 0, 0);
        // R3/R6: 8-bit unsigned wrap to zero.
        apply(2'b00, 64'h0000_0000_0000_00FF, 64'hFFFF_FFFF_FFFF_FF01, 32'd0, 0, 0, 0, 0);
        // R9: 16-bit with upper junk, carry out of bit 15.
        apply(2'b01, 64'hAAAA_AAAA_AAAA_8000, 64'h5555_5555_5555_8000, 32'd0, 0, 0, 0, 0);
        // 32-bit signed overflow positive to negative.
        apply(2'b10, 64'hFFFF_0000_7FFF_FFFF, 64'h0000_0000_0000_0001, 32'd0, 0, 0, 0, 0);
        // 64-bit all ones plus one.
        apply(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 32'd0, 0, 0, 0, 0);
        idle(2);
        // R2: short immediate -1 on 64-bit, long 32-bit negative on 64-bit.
        apply(2'b11, 64'h0000_0000_0000_0005, 64'h0, 32'h0000_00FF, 1, 1, 0, 0);
        apply(2'b11, 64'h1000_0000_0000_0000, 64'h0, 32'h8000_0000, 1, 0, 0, 0);
        // R2: long 16-bit immediate on 16-bit lane ignores imm bits 31:16.
        apply(2'b01, 64'h0000_0000_0000_0001, 64'h0, 32'h7777_FFFF, 1, 0, 0, 0);
        // R2: short immediate on 32-bit lane.
        apply(2'b10, 64'h0000_0000_0000_0080, 64'h0, 32'h1234_5680, 1, 1, 0, 0);
        idle(1);
        // R11: locked register destination faults and holds prior result.
        apply(2'b00, 64'h1, 64'h1, 32'd0, 0, 0, 1, 0);
        apply(2'b00, 64'h2, 64'h3, 32'd0, 0, 0, 0, 0);
        apply(2'b11, 64'h9, 64'h9, 32'd0, 0, 0, 1, 0);
        // R12: locked memory destination completes.
        apply(2'b10, 64'h0000_0000_FFFF_FFFF, 64'h1, 32'd0, 0, 0, 1, 1);
        idle(3);

        // Varied stimulus over widths, immediates and lock cases.
        for (int k = 0; k < 600; k++) begin
            logic [63:0] d, s;
            logic [31:0] im;
            int          pick;
            pick = int'($urandom_range(0, 7));
            d = {$urandom, $urandom};
            s = {$urandom, $urandom};
            im = $urandom;
            if (pick == 0) s = ~d;
            if (pick == 1) s = -d;
            if (pick == 2) d = 64'h8080_8080_8080_8080;
            apply(2'($urandom_range(0, 3)), d, s, im,
                  ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 0),
                  ($urandom_range(0, 9) == 0), ($urandom_range(0, 1) == 0));
            if ($urandom_range(0, 5) == 0) idle(1);
        end
        idle(4);
        if (sb.size() != 0) fail("R10 pending items", 64'(sb.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule